// File: doc/BRIEF.md
# Interrupt-Deferring Atomic Section Controller

This block sits next to a simple in-order CPU pipeline. It makes a short run of instructions atomic with respect to interrupts. When an atomic-section instruction retires, it carries a 4-bit immediate `critImm`. The controller then holds interrupts off until `critImm + 1` further instructions have retired. It counts retire strobes, not clock cycles, so stalls and pipeline bubbles do not shorten the protected span. The block drives an interrupt-enable gate, which the interrupt controller must honour, and a flag that shows a section is running.

Chained sections must not be able to starve interrupts. If an interrupt is pending at the moment a section closes, the controller opens an interrupt window. While that window is open, any atomic-section instruction that retires is ignored, and it stays ignored until the pending request is taken. The interrupt controller shows that a request has been taken by lowering `irqPending`. If nothing is pending when a section closes, the next section may start at once.

Top module: `atomic_guard`

## Requirements
- R1: After reset no section is active: `sectionActive` is 0, `irqEnable` is 1 and no window is open.
- R2: When `critRetire` is high while no section is active and no window is open, `sectionActive` goes high from the next cycle.
- R3: A section covers exactly `critImm + 1` retired instructions. `sectionActive` falls in the cycle after the edge at which the `critImm + 1`-th `instRetire` after the opening is sampled. Encodings: `critImm` = 0 gives 1 instruction and `critImm` = 15 gives 16.
- R4: Cycles in which `instRetire` is low do not advance the section, whatever `critRetire` and `irqPending` do.
- R5: `irqEnable` is low in exactly the cycles in which `sectionActive` is high.
- R6: A `critRetire` while a section is active neither reloads nor extends it. This includes a `critRetire` in the same cycle as the retire that ends the section.
- R7: If `irqPending` is high at the retire that ends a section, a window opens. While `irqPending` stays high, `critRetire` starts no section. The window closes at the first edge at which `irqPending` is sampled low.
- R8: If `irqPending` is low at the retire that ends a section, a `critRetire` in the very next cycle opens a new section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| critRetire | input | 1 | Atomic-section instruction retired this cycle |
| critImm | input | IMM_W | Immediate of that instruction; section length is value + 1 |
| instRetire | input | 1 | An instruction inside the section retired this cycle |
| irqPending | input | 1 | An interrupt request is waiting; falls once it is accepted |
| irqEnable | output | 1 | High when interrupts may be accepted |
| sectionActive | output | 1 | High while an atomic section is open |

## Verification
The bench puts stall cycles inside a section. A design that counted clock cycles instead of retires would close the section early. It issues a second atomic instruction in the middle of a section and on the closing retire. A design that reloaded its counter would stay active too long. It runs both extreme immediates, 0 and 15, which catches off-by-one errors in either direction. It chains sections with an interrupt pending and again with none pending. A design without the forced window would start the chained section and lock the interrupt out. A design that forced the window every time would wrongly refuse the second section.

// File: rtl/atomic_guard_pkg.sv
package atomic_guard_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACTIVE = 2'd1,
    PH_WINDOW = 2'd2
  } phase_t;

  typedef struct packed {
    logic load;
    logic dec;
  } cntStrobe_t;

endpackage

// File: rtl/atomic_guard_count.sv
module atomic_guard_count
  import atomic_guard_pkg::*;
#(
  parameter int IMM_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [IMM_W-1:0] loadVal,
  output logic [IMM_W-1:0] count,
  output logic             atZero
);

  localparam logic [IMM_W-1:0] ONE = IMM_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.load) begin
      count <= loadVal;
    end else if (strobe.dec) begin
      count <= count - ONE;
    end
  end

  assign atZero = (count == '0);

endmodule

// File: rtl/atomic_guard_ctrl.sv
module atomic_guard_ctrl
  import atomic_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       critRetire,
  input  logic       instRetire,
  input  logic       irqPending,
  input  logic       atZero,
  output cntStrobe_t strobe,
  output phase_t     phase
);

  phase_t phaseNext;

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    unique case (phase)
      PH_IDLE: begin
        if (critRetire) begin
          strobe.load = 1'b1;
          phaseNext   = PH_ACTIVE;
        end
      end
      PH_ACTIVE: begin
        if (instRetire) begin
          if (atZero) begin
            phaseNext = irqPending ? PH_WINDOW : PH_IDLE;
          end else begin
            strobe.dec = 1'b1;
          end
        end
      end
      PH_WINDOW: begin
        if (!irqPending) phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

endmodule

// File: rtl/atomic_guard.sv
module atomic_guard
  import atomic_guard_pkg::*;
#(
  parameter int IMM_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             critRetire,
  input  logic [IMM_W-1:0] critImm,
  input  logic             instRetire,
  input  logic             irqPending,
  output logic             irqEnable,
  output logic             sectionActive
);

  cntStrobe_t       strobe;
  phase_t           phase;
  logic [IMM_W-1:0] count;
  logic             atZero;

  atomic_guard_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .critRetire (critRetire),
    .instRetire (instRetire),
    .irqPending (irqPending),
    .atZero     (atZero),
    .strobe     (strobe),
    .phase      (phase)
  );

  atomic_guard_count #(.IMM_W(IMM_W)) u_count (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .loadVal (critImm),
    .count   (count),
    .atZero  (atZero)
  );

  assign sectionActive = (phase == PH_ACTIVE);
  assign irqEnable     = (phase != PH_ACTIVE);

endmodule

// File: rtl/atomic_guard_chk.sv
module atomic_guard_chk
  import atomic_guard_pkg::*;
#(
  parameter int IMM_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             critRetire,
  input logic             instRetire,
  input logic             irqPending,
  input logic             irqEnable,
  input logic             sectionActive,
  input phase_t           phase,
  input logic [IMM_W-1:0] count
);

  // R2: an allowed start opens the section on the next cycle
  a_r2_start: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && critRetire) |=> sectionActive);

  // R3: a retire with count left keeps the section open and steps the count
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (sectionActive && instRetire && count != '0) |=>
      (sectionActive && count == $past(count) - IMM_W'(1)));

  // R3: the retire at zero count closes the section
  a_r3_close: assert property (@(posedge clk) disable iff (!rstN)
    (sectionActive && instRetire && count == '0) |=> !sectionActive);

  // R4 and R6: without a retire the section and its count hold
  a_r4_stall: assert property (@(posedge clk) disable iff (!rstN)
    (sectionActive && !instRetire) |=> (sectionActive && $stable(count)));

  // R5: the gate and the flag are never both high or both low
  a_r5_gate: assert property (@(posedge clk) disable iff (!rstN)
    irqEnable != sectionActive);

  // R7: a pending request at close forces the window
  a_r7_window: assert property (@(posedge clk) disable iff (!rstN)
    (sectionActive && instRetire && count == '0 && irqPending) |=>
      (phase == PH_WINDOW));

  // R7: inside the window an atomic instruction opens nothing
  a_r7_block: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WINDOW && critRetire) |=> !sectionActive);

endmodule

bind atomic_guard atomic_guard_chk #(.IMM_W(IMM_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .critRetire    (critRetire),
  .instRetire    (instRetire),
  .irqPending    (irqPending),
  .irqEnable     (irqEnable),
  .sectionActive (sectionActive),
  .phase         (phase),
  .count         (count)
);

// File: tb/sim_atomic_guard.sv
module sim_atomic_guard;

  localparam int CLK_PERIOD = 10;
  localparam int IMM_W      = 4;
  localparam int WATCHDOG   = 5000;

  typedef struct {
    int    due;
    logic  expActive;
    string req;
  } item_t;

  logic             clk = 1'b0;
  logic             rstN;
  logic             critRetire;
  logic [IMM_W-1:0] critImm;
  logic             instRetire;
  logic             irqPending;
  logic             irqEnable;
  logic             sectionActive;

  int    cyc = 0;
  int    nCompared = 0;
  int    nMismatched = 0;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  atomic_guard #(.IMM_W(IMM_W)) u0 (
    .clk           (clk),
    .rstN          (rstN),
    .critRetire    (critRetire),
    .critImm       (critImm),
    .instRetire    (instRetire),
    .irqPending    (irqPending),
    .irqEnable     (irqEnable),
    .sectionActive (sectionActive)
  );

  // Drive one cycle of inputs at a falling edge; expect the result after the next rising edge
  task automatic step(input logic c, input int imm, input logic r, input logic irq,
                      input logic expA, input string req);
    item_t it;
    critRetire = c;
    critImm    = IMM_W'(imm);
    instRetire = r;
    irqPending = irq;
    it.due = cyc + 1;
    it.expActive = expA;
    it.req = req;
    sb.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: pop due items and compare at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      nCompared++;
      if (sectionActive !== it.expActive) begin
        nMismatched++;
        $display("FAIL %s: sectionActive=%0b expected %0b (cycle %0d)",
                 it.req, sectionActive, it.expActive, cyc);
      end
      nCompared++;
      if (irqEnable !== !it.expActive) begin
        nMismatched++;
        $display("FAIL R5 (%s): irqEnable=%0b expected %0b (cycle %0d)",
                 it.req, irqEnable, !it.expActive, cyc);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nMismatched++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; critRetire = 0; critImm = '0; instRetire = 0; irqPending = 0;
    repeat (3) @(negedge clk);
    // R1: reset state seen directly at the ports
    nCompared++;
    if (sectionActive !== 1'b0 || irqEnable !== 1'b1) begin
      nMismatched++;
      $display("FAIL R1: active=%0b en=%0b expected 0 1", sectionActive, irqEnable);
    end
    rstN = 1'b1;
    step(0, 0, 1, 1, 0, "R1");           // retire with no section: nothing opens

    // R2, R3: imm 2 covers three retires
    step(1, 2, 0, 0, 1, "R2");
    step(0, 0, 1, 0, 1, "R3");
    step(0, 0, 1, 0, 1, "R3");
    step(0, 0, 1, 0, 0, "R3");

    // R4: stalls between retires do not count
    step(1, 1, 0, 0, 1, "R2");
    step(0, 0, 0, 1, 1, "R4");
    step(0, 0, 0, 0, 1, "R4");
    step(0, 0, 0, 1, 1, "R4");
    step(0, 0, 1, 0, 1, "R3");
    step(0, 0, 0, 0, 1, "R4");
    step(0, 0, 1, 0, 0, "R3");

    // R3: imm 0 gives one instruction
    step(1, 0, 0, 0, 1, "R2");
    step(0, 0, 1, 0, 0, "R3");

    // R3: imm 15 gives sixteen instructions
    step(1, 15, 0, 0, 1, "R2");
    for (int i = 0; i < 15; i++) step(0, 0, 1, 0, 1, "R3");
    step(0, 0, 1, 0, 0, "R3");

    // R6: CRIT mid-section does not reload
    step(1, 3, 0, 0, 1, "R2");
    step(1, 7, 0, 0, 1, "R6");
    step(0, 0, 1, 0, 1, "R6");
    step(1, 9, 1, 0, 1, "R6");
    step(0, 0, 1, 0, 1, "R6");
    step(0, 0, 1, 0, 0, "R6");
    // R6: CRIT on the closing retire is ignored
    step(1, 1, 0, 0, 1, "R2");
    step(0, 0, 1, 0, 1, "R3");
    step(1, 5, 1, 0, 0, "R6");
    step(0, 0, 0, 0, 0, "R6");

    // R7: pending interrupt at close forces a window
    step(1, 0, 0, 1, 1, "R2");
    step(0, 0, 1, 1, 0, "R7");
    step(1, 3, 0, 1, 0, "R7");
    step(1, 2, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 0, "R7");           // request accepted: window closes
    step(1, 1, 0, 0, 1, "R7");
    step(0, 0, 1, 0, 1, "R3");
    step(0, 0, 1, 0, 0, "R3");

    // R8: nothing pending at close: immediate restart
    step(1, 0, 0, 0, 1, "R2");
    step(0, 0, 1, 0, 0, "R8");
    step(1, 0, 0, 1, 1, "R8");
    step(0, 0, 1, 0, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

endmodule